// File: doc/BRIEF.md
# Calorimeter Channel Correction Pipeline

This block corrects digitized detector samples for several channels and derives one trigger bit per channel. Each sample has a per-channel pedestal subtracted. It is then scaled by a gain slightly above one. Last, a fraction of that channel's previous corrected output is removed. The corrected word is compared with a per-channel threshold. Data word and trigger bit leave the block in the same cycle, four sample strobes after the sample entered.

Channels come in pairs. In direct mode each pair receives two parallel sample lanes at the sample rate. In interleaved mode one lane carries both channels of the pair at twice the sample rate. The block holds the first half of each interleaved pair and realigns it with the second half, so both channels enter the pipeline together. The block runs on a single fast clock. A sample strobe `smp_en` marks the cycles in which the pipeline advances; it is high in every other cycle.

Correction constants are written one field at a time through a parallel load port. All constants are zero after reset.

Top module: `calo_corr_pipe`

## Requirements
- R1: While `rst_n` is low, every data word and every trigger bit is 0, and all loaded constants are 0.
- R2: A sample captured at a strobe edge appears on `dat_out` and `trg_out` right after the fourth strobe edge counted from its own. The outputs change only at edges where `smp_en` is high.
- R3: The stage-one result is the raw sample minus the 8-bit pedestal, clamped at 0.
- R4: The stage-two result is v + floor(v*G/512), where G is the 8-bit gain field. It is clamped to 1023.
- R5: The output is w - floor(p*A/512), clamped at 0. Here A is the 8-bit alpha field and p is the channel's previous `dat_out` word; p is 0 after reset.
- R6: `trg_out[c]` is 1 exactly when the data word leaving with it is strictly greater than the zero-extended 8-bit threshold of channel c.
- R7: With `mux_mode` = 0, channel 2p takes `raw_a` lane p and channel 2p+1 takes `raw_b` lane p, both sampled in the strobe cycle. Lanes are 10 bits wide with lane p at bits [10p+9:10p]. Lane values outside strobe cycles are ignored.
- R8: With `mux_mode` = 1, channel 2p takes `raw_a` lane p from the cycle just before the strobe (`smp_en` low). Channel 2p+1 takes `raw_a` lane p from the strobe cycle. `raw_b` is ignored.
- R9: A clock edge with `cfg_we` high writes `cfg_data` into one field of channel `cfg_ch`. `cfg_sel` picks the field: 0 pedestal, 1 gain, 2 alpha, 3 threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (twice the sample rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| mux_mode | input | 1 | 0 direct lanes, 1 interleaved stream on `raw_a` |
| smp_en | input | 1 | Sample strobe; pipeline advances at these edges |
| raw_a | input | N_PAIR*10 | First sample lane per pair (interleaved stream in mode 1) |
| raw_b | input | N_PAIR*10 | Second sample lane per pair (direct mode only) |
| cfg_we | input | 1 | Constant write enable |
| cfg_ch | input | log2(2*N_PAIR) | Channel addressed by the write |
| cfg_sel | input | 2 | Field selector: 0 pedestal, 1 gain, 2 alpha, 3 threshold |
| cfg_data | input | 8 | Value written |
| dat_out | output | 2*N_PAIR*10 | Corrected word per channel, channel c at bits [10c+9:10c] |
| trg_out | output | 2*N_PAIR | Trigger bit per channel |

## Verification
The assertions check on every cycle that:
- the outputs are cleared during reset;
- the outputs hold still on non-strobe cycles;
- each trigger bit agrees with the data word beside it and the current threshold;
- a threshold write lands in the addressed channel.

The arithmetic cannot be seen by a single-cycle property and is left to the bench scenarios. This covers pedestal clamping, gain truncation and saturation, the recursive alpha subtraction, the four-strobe latency, and the routing of lanes in both input modes. The bench's reference model follows each channel's previous output through long sample runs.

// File: rtl/calo_corr_pipe.sv
module calo_corr_pipe #(
  parameter int N_PAIR = 2,
  parameter int RAW_W  = 10,
  parameter int PAR_W  = 8,
  parameter int FRAC   = 9,
  localparam int N_CH  = 2 * N_PAIR,
  localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mux_mode,
  input  logic                    smp_en,
  input  logic [N_PAIR*RAW_W-1:0] raw_a,
  input  logic [N_PAIR*RAW_W-1:0] raw_b,
  input  logic                    cfg_we,
  input  logic [CH_W-1:0]         cfg_ch,
  input  logic [1:0]              cfg_sel,
  input  logic [PAR_W-1:0]        cfg_data,
  output logic [N_CH*RAW_W-1:0]   dat_out,
  output logic [N_CH-1:0]         trg_out
);

  localparam int PROD_W = RAW_W + PAR_W;
  localparam logic [RAW_W-1:0] MAXV = {RAW_W{1'b1}};

  logic [PAR_W-1:0] off_r  [N_CH];
  logic [PAR_W-1:0] gain_r [N_CH];
  logic [PAR_W-1:0] alp_r  [N_CH];
  logic [PAR_W-1:0] thr_r  [N_CH];
  logic [N_CH*PAR_W-1:0] thr_flat;
  logic [RAW_W-1:0] hold_a [N_PAIR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CH; i++) begin
        off_r[i]  <= '0;
        gain_r[i] <= '0;
        alp_r[i]  <= '0;
        thr_r[i]  <= '0;
      end
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: off_r[cfg_ch]  <= cfg_data;
        2'd1: gain_r[cfg_ch] <= cfg_data;
        2'd2: alp_r[cfg_ch]  <= cfg_data;
        default: thr_r[cfg_ch] <= cfg_data;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < N_PAIR; p++) hold_a[p] <= '0;
    end else if (!smp_en) begin
      for (int p = 0; p < N_PAIR; p++) hold_a[p] <= raw_a[p*RAW_W +: RAW_W];
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    localparam int P = g / 2;
    logic [RAW_W-1:0]  raw_in, s1, s2, s3, s4;
    logic [RAW_W-1:0]  sub_v, gain_v, alp_v;
    logic [RAW_W:0]    dif1, gsum, dif2;
    logic [PROD_W-1:0] gprod, aprod;
    logic              trg_v, trg_q;

    if (g % 2 == 0) begin : g_even
      assign raw_in = mux_mode ? hold_a[P] : raw_a[P*RAW_W +: RAW_W];
    end else begin : g_odd
      assign raw_in = mux_mode ? raw_a[P*RAW_W +: RAW_W] : raw_b[P*RAW_W +: RAW_W];
    end

    assign dif1   = {1'b0, s1} - {{(RAW_W-PAR_W+1){1'b0}}, off_r[g]};
    assign sub_v  = dif1[RAW_W] ? '0 : dif1[RAW_W-1:0];

    assign gprod  = {{PAR_W{1'b0}}, s2} * {{RAW_W{1'b0}}, gain_r[g]};
    assign gsum   = {1'b0, s2} + (RAW_W+1)'(gprod >> FRAC);
    assign gain_v = gsum[RAW_W] ? MAXV : gsum[RAW_W-1:0];

    assign aprod  = {{PAR_W{1'b0}}, s4} * {{RAW_W{1'b0}}, alp_r[g]};
    assign dif2   = {1'b0, s3} - {1'b0, RAW_W'(aprod >> FRAC)};
    assign alp_v  = dif2[RAW_W] ? '0 : dif2[RAW_W-1:0];
    assign trg_v  = alp_v > {{(RAW_W-PAR_W){1'b0}}, thr_r[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= '0; s2 <= '0; s3 <= '0; s4 <= '0; trg_q <= 1'b0;
      end else if (smp_en) begin
        s1    <= raw_in;
        s2    <= sub_v;
        s3    <= gain_v;
        s4    <= alp_v;
        trg_q <= trg_v;
      end
    end

    assign dat_out[g*RAW_W +: RAW_W] = s4;
    assign trg_out[g]                = trg_q;
    assign thr_flat[g*PAR_W +: PAR_W] = thr_r[g];
  end

endmodule

// File: rtl/calo_corr_pipe_chk.sv
module calo_corr_pipe_chk #(
  parameter int N_CH  = 4,
  parameter int RAW_W = 10,
  parameter int PAR_W = 8,
  parameter int CH_W  = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  smp_en,
  input logic                  cfg_we,
  input logic [CH_W-1:0]       cfg_ch,
  input logic [1:0]            cfg_sel,
  input logic [PAR_W-1:0]      cfg_data,
  input logic [N_CH*PAR_W-1:0] thr_flat,
  input logic [N_CH*RAW_W-1:0] dat_out,
  input logic [N_CH-1:0]       trg_out
);

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |-> (dat_out == '0 && trg_out == '0)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> ($stable(dat_out) && $stable(trg_out))); // R2

  for (genvar g = 0; g < N_CH; g++) begin : g_chk
    AST_TRIG_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(smp_en) && $stable(thr_flat[g*PAR_W +: PAR_W])) |->
      (trg_out[g] == (dat_out[g*RAW_W +: RAW_W] > {{(RAW_W-PAR_W){1'b0}}, thr_flat[g*PAR_W +: PAR_W]}))); // R6

    AST_THR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == 2'd3 && cfg_ch == CH_W'(g)) |=>
      (thr_flat[g*PAR_W +: PAR_W] == $past(cfg_data))); // R9
  end

endmodule

bind calo_corr_pipe calo_corr_pipe_chk #(
  .N_CH(N_CH), .RAW_W(RAW_W), .PAR_W(PAR_W), .CH_W(CH_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
  .cfg_sel(cfg_sel), .cfg_data(cfg_data), .thr_flat(thr_flat),
  .dat_out(dat_out), .trg_out(trg_out)
);

// File: tb/calo_corr_pipe_tb.sv
module calo_corr_pipe_tb_top;
  localparam int NP = 2;
  localparam int NC = 4;
  localparam int RW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mux_mode = 1'b0;
  logic smp_en = 1'b0;
  logic [NP*RW-1:0] raw_a = '0;
  logic [NP*RW-1:0] raw_b = '0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_ch = '0;
  logic [1:0] cfg_sel = '0;
  logic [7:0] cfg_data = '0;
  logic [NC*RW-1:0] dat_out;
  logic [NC-1:0] trg_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string tag = "R1";
  int m_off[NC], m_g[NC], m_a[NC], m_thr[NC];
  int e_dat[NC];
  bit e_trg[NC];
  int pend[NC];
  int q[$];

  calo_corr_pipe #(.N_PAIR(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .mux_mode(mux_mode), .smp_en(smp_en),
    .raw_a(raw_a), .raw_b(raw_b), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .dat_out(dat_out), .trg_out(trg_out)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", t, act, exp);
    end
  endtask

  function automatic int corr(input int x, input int c);
    int a, b, d;
    a = x - m_off[c];
    if (a < 0) a = 0;
    b = a + (a * m_g[c]) / 512;
    if (b > 1023) b = 1023;
    d = b - (e_dat[c] * m_a[c]) / 512;
    if (d < 0) d = 0;
    return d;
  endfunction

  task automatic model_strobe();
    for (int c = 0; c < NC; c++) q.push_back(pend[c]);
    if (q.size() == 4 * NC) begin
      for (int c = 0; c < NC; c++) begin
        int x, d;
        x = q.pop_front();
        d = corr(x, c);
        e_dat[c] = d;
        e_trg[c] = (d > m_thr[c]);
      end
    end
  endtask

  task automatic compare();
    for (int c = 0; c < NC; c++) begin
      chk(int'(dat_out[c*RW +: RW]) == e_dat[c], $sformatf("%s ch%0d data", tag, c),
          int'(dat_out[c*RW +: RW]), e_dat[c]);
      chk(trg_out[c] == e_trg[c], $sformatf("R6 %s ch%0d trigger", tag, c),
          int'(trg_out[c]), int'(e_trg[c]));
    end
  endtask

  task automatic step();
    bit strobe;
    strobe = smp_en && rst_n;
    @(posedge clk);
    #1;
    if (strobe) model_strobe();
    @(negedge clk);
    compare();
  endtask

  task automatic cfg(input int ch, input int sel, input int val);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_data = 8'(val);
    step();
    cfg_we = 1'b0;
    case (sel)
      0: m_off[ch] = val;
      1: m_g[ch] = val;
      2: m_a[ch] = val;
      default: m_thr[ch] = val;
    endcase
  endtask

  task automatic cfg_all(input int sel, input int v0, input int v1, input int v2, input int v3);
    cfg(0, sel, v0); cfg(1, sel, v1); cfg(2, sel, v2); cfg(3, sel, v3);
  endtask

  task automatic period(input int av[NP], input int bv[NP]);
    smp_en = 1'b0;
    for (int p = 0; p < NP; p++) begin
      raw_a[p*RW +: RW] = mux_mode ? RW'(av[p]) : RW'($urandom);
      raw_b[p*RW +: RW] = RW'($urandom);
    end
    step();
    smp_en = 1'b1;
    for (int p = 0; p < NP; p++) begin
      raw_a[p*RW +: RW] = mux_mode ? RW'(bv[p]) : RW'(av[p]);
      raw_b[p*RW +: RW] = mux_mode ? RW'($urandom) : RW'(bv[p]);
      pend[2*p] = av[p];
      pend[2*p+1] = bv[p];
    end
    step();
    smp_en = 1'b0;
  endtask

  task automatic flush();
    for (int k = 0; k < 4; k++) period('{0, 0}, '{0, 0});
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R2 act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NC; c++) begin
      m_off[c] = 0; m_g[c] = 0; m_a[c] = 0; m_thr[c] = 0; e_dat[c] = 0; e_trg[c] = 0;
    end
    tag = "R1 reset";
    raw_a = '1; raw_b = '1;
    step(); step();
    rst_n = 1'b1;
    step();

    tag = "R2/R7 direct";
    for (int k = 0; k < 8; k++) period('{10 * k + 1, 300 + k}, '{1023 - k, 5 * k});
    flush();

    tag = "R3/R9 offset";
    cfg_all(0, 50, 255, 0, 7);
    period('{40, 0}, '{255, 6});
    period('{50, 1023}, '{256, 7});
    period('{51, 8}, '{1023, 1000});
    period('{1023, 3}, '{254, 9});
    flush();
    cfg_all(0, 0, 0, 0, 0);

    tag = "R4/R9 gain";
    cfg_all(1, 255, 128, 1, 0);
    period('{1023, 600}, '{700, 1023});
    period('{3, 511}, '{511, 2});
    period('{683, 1023}, '{1, 12});
    period('{684, 1}, '{1023, 600});
    flush();
    cfg_all(1, 0, 0, 0, 0);

    tag = "R5/R9 alpha";
    cfg_all(2, 255, 128, 64, 0);
    for (int k = 0; k < 6; k++) period('{1000, 1000}, '{1000, 1000});
    for (int k = 0; k < 3; k++) period('{10, 300}, '{0, 200});
    period('{1023, 1023}, '{1023, 1023});
    flush();
    cfg_all(2, 0, 0, 0, 0);

    tag = "R6 threshold";
    cfg_all(3, 100, 100, 255, 0);
    period('{99, 100}, '{255, 0});
    period('{100, 101}, '{256, 1});
    period('{101, 99}, '{1023, 2});
    period('{100, 100}, '{255, 0});
    flush();

    tag = "R8 mux";
    mux_mode = 1'b1;
    cfg_all(0, 5, 0, 20, 0);
    cfg_all(3, 50, 60, 70, 80);
    for (int k = 0; k < 10; k++) period('{17 * k, 1000 - 31 * k}, '{900 - 7 * k, 3 * k + 60});
    flush();

    tag = "R3/R4/R5/R6 random";
    for (int r = 0; r < 6; r++) begin
      mux_mode = r[0];
      for (int s = 0; s < 4; s++)
        for (int c = 0; c < NC; c++) cfg(c, s, int'($urandom_range(0, 255)));
      for (int k = 0; k < 40; k++)
        period('{int'($urandom_range(0, 1023)), int'($urandom_range(0, 1023))},
               '{int'($urandom_range(0, 1023)), int'($urandom_range(0, 1023))});
      flush();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule